// File: doc/BRIEF.md
# Dual Down-Counting Timer with Keyed Watchdog

This block provides two independent 32-bit down-counting timers and a watchdog, reached through a simple word-addressed register port. Each timer has its own mode, count and reload registers. It can tick on every core clock or on every 4th, 8th or 16th clock. It either stops at zero (one-shot) or reloads itself and keeps going (auto-reload). A shared status register holds a sticky terminal-count bit for each timer, and each timer drives its own interrupt line from that bit.

The watchdog stays idle until software writes two fixed key words back to back into its control register. Once armed it counts down from a start value set by a parameter. Repeating the two-word sequence services it. If the count reaches zero, a reset-request output goes high and stays high until the block is reset. Nothing short of a reset can disarm it.

Writes take one clock edge to land and reads are combinational from the word address. The reset input is asynchronous and active-low, and it is released to the logic through a two-stage synchronizer.

Top module: `dual_timer_wdog`

## Requirements
- R1: After reset every register reads zero, both interrupt lines are low and the reset request is low.
- R2: Word addresses: 0 mode of timer 0, 1 mode of timer 1, 2 count 0, 3 count 1, 4 reload 0, 5 reload 1, 6 status, 7 watchdog (write keys, read remaining count). Mode bits: bit 0 terminal-count flag (read-only), bit 1 enable, bit 2 auto-reload, bits 5:4 tick select; all other mode bits read zero. Status bit 0 belongs to timer 0 and bit 1 to timer 1.
- R3: An enabled timer decrements its count by one on each tick; with tick select 0 it ticks on every clock edge, starting at the first edge after the enabling write.
- R4: Tick select 1, 2 and 3 divide the clock by 4, 8 and 16. The divider restarts whenever the timer is disabled, so the first decrement lands on the Nth edge after the enabling write, where N is the division ratio.
- R5: In one-shot mode, a tick that finds the count at 1 or 0 leaves the count at 0, sets the terminal-count flag and status bit, and clears the enable bit.
- R6: In auto-reload mode, that same tick loads the count from the reload register, sets the terminal-count flag and status bit, and leaves the timer enabled.
- R7: Status bits are sticky and cleared by writing 1 to them. Bits written with 0 keep their value. Clearing a status bit also clears the matching mode flag. Interrupt line n equals status bit n.
- R8: A count-register write is visible after the next edge and takes priority over a decrement in that cycle.
- R9: The watchdog is armed only by writing 0x1E1E1E1E and, as the very next watchdog write, 0xE1E1E1E1. Any other value after the first key cancels the sequence.
- R10: When armed, or when the sequence is repeated, the watchdog count is loaded with the start value and then drops by one every clock. No write can disarm it. Before arming it reads zero.
- R11: On the edge after the watchdog count reads zero, the reset request goes high and stays high until reset, whatever is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 3 | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| tmr_irq | output | 2 | Per-timer interrupt, follows the status bits |
| wdog_reset_req | output | 1 | Watchdog expiry, sticky until reset |

## Verification
The assertions assume that the write strobe is never X after reset. They also assume that a timer mode register is not rewritten in the same cycle as that timer's terminal tick; one-shot stopping is only checked when no mode or count write collides with the hit. The directed stimulus changes inputs on the falling edge only. It stops each timer with a mode write well away from any terminal tick, and it leaves the watchdog untouched for whole counting windows, so these assumptions always hold. Expected counts come from edge arithmetic measured from each write.

// File: rtl/dtw_pkg.sv
package dtw_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int PS_W   = 4;   // enough for the largest ratio of 16

  typedef enum logic [ADDR_W-1:0] {
    A_MODE0  = 3'd0,
    A_MODE1  = 3'd1,
    A_COUNT0 = 3'd2,
    A_COUNT1 = 3'd3,
    A_RELD0  = 3'd4,
    A_RELD1  = 3'd5,
    A_STAT   = 3'd6,
    A_WDOG   = 3'd7
  } reg_sel_e;

  // mode register field positions
  localparam int MB_TC   = 0;
  localparam int MB_EN   = 1;
  localparam int MB_AUTO = 2;
  localparam int MB_SEL  = 4;

  localparam logic [DATA_W-1:0] WD_KEY_A = 32'h1E1E_1E1E;
  localparam logic [DATA_W-1:0] WD_KEY_B = 32'hE1E1_E1E1;
endpackage

// File: rtl/dtw_prescale.sv
module dtw_prescale
  import dtw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [PS_W-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    case (sel)
      2'd0:    lim = PS_W'(0);
      2'd1:    lim = PS_W'(3);
      2'd2:    lim = PS_W'(7);
      default: lim = PS_W'(15);
    endcase
  end

  assign tick = run && (cnt_q == lim);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + PS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: a divided tick is never followed at once by another
  assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!tick || sel == 2'd0));
endmodule

// File: rtl/dtw_timer_chan.sv
module dtw_timer_chan
  import dtw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mode,
  input  logic              wr_count,
  input  logic              wr_reload,
  input  logic              clr_tc,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mode_rd,
  output logic [DATA_W-1:0] count_q,
  output logic [DATA_W-1:0] reload_q,
  output logic              tc_q
);
  logic              en_q, en_d;
  logic              auto_q;
  logic [1:0]        sel_q;
  logic              tc_d;
  logic [DATA_W-1:0] count_d;
  logic              tick, hit;

  dtw_prescale u_ps (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (en_q),
    .sel  (sel_q),
    .tick (tick)
  );

  assign hit = tick && (count_q <= DATA_W'(1));

  always_comb begin
    if (wr_count)  count_d = wdata;
    else if (hit)  count_d = auto_q ? reload_q : '0;
    else if (tick) count_d = count_q - DATA_W'(1);
    else           count_d = count_q;
  end

  always_comb begin
    if (wr_mode)             en_d = wdata[MB_EN];
    else if (hit && !auto_q) en_d = 1'b0;
    else                     en_d = en_q;
  end

  always_comb begin
    if (hit)         tc_d = 1'b1;
    else if (clr_tc) tc_d = 1'b0;
    else             tc_d = tc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      en_q    <= 1'b0;
      tc_q    <= 1'b0;
    end else begin
      count_q <= count_d;
      en_q    <= en_d;
      tc_q    <= tc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_q <= 1'b0;
      sel_q  <= 2'd0;
    end else if (wr_mode) begin
      auto_q <= wdata[MB_AUTO];
      sel_q  <= wdata[MB_SEL +: 2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reload_q <= '0;
    else if (wr_reload) reload_q <= wdata;
  end

  always_comb begin
    mode_rd             = '0;
    mode_rd[MB_TC]      = tc_q;
    mode_rd[MB_EN]      = en_q;
    mode_rd[MB_AUTO]    = auto_q;
    mode_rd[MB_SEL +: 2] = sel_q;
  end

  assert_oneshot_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !auto_q && !wr_mode && !wr_count) |=> (!en_q && count_q == '0 && tc_q));

  assert_autoreload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && auto_q && !wr_count) |=> (count_q == $past(reload_q) && tc_q));

  assert_tc_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_q && !clr_tc) |=> tc_q);

  assert_count_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_count |=> (count_q == $past(wdata)));
endmodule

// File: rtl/dtw_wdog.sv
module dtw_wdog
  import dtw_pkg::*;
#(
  parameter int WD_W     = 32,
  parameter int WD_START = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [WD_W-1:0]   cnt_q,
  output logic              rst_req_q
);
  localparam logic [WD_W-1:0] START_V = WD_W'(WD_START);

  logic            key_q, key_d;
  logic            armed_q, armed_d;
  logic            service;
  logic [WD_W-1:0] cnt_d;
  logic            rst_req_d;

  assign service = wr && key_q && (wdata == WD_KEY_B);

  always_comb begin
    key_d = key_q;
    if (wr) key_d = (wdata == WD_KEY_A);
  end

  assign armed_d = armed_q | service;

  always_comb begin
    cnt_d     = cnt_q;
    rst_req_d = rst_req_q;
    if (!rst_req_q) begin
      if (service)                  cnt_d = START_V;
      else if (armed_q) begin
        if (cnt_q == '0)            rst_req_d = 1'b1;
        else                        cnt_d = cnt_q - WD_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q     <= 1'b0;
      armed_q   <= 1'b0;
      cnt_q     <= '0;
      rst_req_q <= 1'b0;
    end else begin
      key_q     <= key_d;
      armed_q   <= armed_d;
      cnt_q     <= cnt_d;
      rst_req_q <= rst_req_d;
    end
  end

  assert_service_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (service && !rst_req_q) |=> (cnt_q == START_V));

  assert_armed_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q);

  assert_reset_req_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |=> rst_req_q);

  assert_no_early_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_req_q && cnt_q != '0) |=> !rst_req_q);
endmodule

// File: rtl/dual_timer_wdog.sv
module dual_timer_wdog
  import dtw_pkg::*;
#(
  parameter int WD_W     = 32,
  parameter int WD_START = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [1:0]        tmr_irq,
  output logic              wdog_reset_req
);
  localparam int NUM_TMR = 2;

  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_addr);

  logic [DATA_W-1:0] mode_rd  [NUM_TMR];
  logic [DATA_W-1:0] count_rd [NUM_TMR];
  logic [DATA_W-1:0] reld_rd  [NUM_TMR];
  logic [NUM_TMR-1:0] tc;
  logic [WD_W-1:0]   wd_cnt;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    logic wr_m, wr_c, wr_r, clr;
    assign wr_m = reg_wr && (reg_addr == ADDR_W'(A_MODE0)  + ADDR_W'(i));
    assign wr_c = reg_wr && (reg_addr == ADDR_W'(A_COUNT0) + ADDR_W'(i));
    assign wr_r = reg_wr && (reg_addr == ADDR_W'(A_RELD0)  + ADDR_W'(i));
    assign clr  = reg_wr && (sel == A_STAT) && reg_wdata[i];

    dtw_timer_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_sync_q),
      .wr_mode  (wr_m),
      .wr_count (wr_c),
      .wr_reload(wr_r),
      .clr_tc   (clr),
      .wdata    (reg_wdata),
      .mode_rd  (mode_rd[i]),
      .count_q  (count_rd[i]),
      .reload_q (reld_rd[i]),
      .tc_q     (tc[i])
    );
  end

  dtw_wdog #(.WD_W(WD_W), .WD_START(WD_START)) u_wdog (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .wr       (reg_wr && (sel == A_WDOG)),
    .wdata    (reg_wdata),
    .cnt_q    (wd_cnt),
    .rst_req_q(wdog_reset_req)
  );

  assign tmr_irq = tc;

  always_comb begin
    case (sel)
      A_MODE0:  reg_rdata = mode_rd[0];
      A_MODE1:  reg_rdata = mode_rd[1];
      A_COUNT0: reg_rdata = count_rd[0];
      A_COUNT1: reg_rdata = count_rd[1];
      A_RELD0:  reg_rdata = reld_rd[0];
      A_RELD1:  reg_rdata = reld_rd[1];
      A_STAT:   reg_rdata = DATA_W'(tc);
      default:  reg_rdata = DATA_W'(wd_cnt);
    endcase
  end
endmodule

// File: tb/dual_timer_wdog_tb_top.sv
module dual_timer_wdog_tb_top;
  localparam int WDS = 40;
  localparam logic [31:0] KA = 32'h1E1E_1E1E;
  localparam logic [31:0] KB = 32'hE1E1_E1E1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [1:0]  tmr_irq;
  logic        wdog_reset_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_timer_wdog #(.WD_W(32), .WD_START(WDS)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_irq(tmr_irq),
    .wdog_reset_req(wdog_reset_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R1 reset register", v, 32'h0);
    end
    check("R1 irq", 32'(tmr_irq), 32'h0);
    check("R1 reset request", 32'(wdog_reset_req), 32'h0);
  endtask

  task automatic t_oneshot;
    logic [31:0] v;
    wr(3'd2, 32'd5);
    wr(3'd0, 32'h2);
    edges(2);
    rd(3'd2, v); check("R3 count after two edges", v, 32'd3);
    edges(3);
    rd(3'd2, v); check("R5 count at zero", v, 32'd0);
    rd(3'd0, v); check("R5 mode tc set enable off", v, 32'h1);
    rd(3'd6, v); check("R2 status bit0", v, 32'h1);
    check("R7 irq0 high", 32'(tmr_irq), 32'h1);
    wr(3'd6, 32'h1);
    rd(3'd6, v); check("R7 status cleared", v, 32'h0);
    rd(3'd0, v); check("R7 mode flag cleared", v, 32'h0);
    check("R7 irq0 low", 32'(tmr_irq), 32'h0);
  endtask

  task automatic t_div4;
    logic [31:0] v;
    wr(3'd3, 32'd3);
    wr(3'd1, 32'h12);
    edges(3);
    rd(3'd3, v); check("R4 no decrement before 4 edges", v, 32'd3);
    edges(1);
    rd(3'd3, v); check("R4 first decrement at edge 4", v, 32'd2);
    edges(8);
    rd(3'd3, v); check("R4 count1 zero after 12 edges", v, 32'd0);
    rd(3'd1, v); check("R5 mode1 readback", v, 32'h11);
    check("R7 irq1 high", 32'(tmr_irq), 32'h2);
  endtask

  task automatic t_partial_clear;
    logic [31:0] v;
    wr(3'd2, 32'd1);
    wr(3'd0, 32'h2);
    edges(1);
    rd(3'd6, v); check("R7 both status bits", v, 32'h3);
    wr(3'd6, 32'h1);
    rd(3'd6, v); check("R7 bit1 kept when written 0", v, 32'h2);
    check("R7 irq follows status", 32'(tmr_irq), 32'h2);
    wr(3'd6, 32'h2);
    rd(3'd6, v); check("R7 bit1 cleared", v, 32'h0);
  endtask

  task automatic t_autoreload;
    logic [31:0] v;
    wr(3'd4, 32'd3);
    wr(3'd2, 32'd3);
    wr(3'd0, 32'h6);
    edges(3);
    rd(3'd2, v); check("R6 reloaded count", v, 32'd3);
    rd(3'd0, v); check("R6 stays enabled with flag", v, 32'h7);
    rd(3'd4, v); check("R2 reload readback", v, 32'd3);
    wr(3'd6, 32'h1);
    rd(3'd6, v); check("R7 clear while running", v, 32'h0);
    edges(2);
    rd(3'd6, v); check("R6 second period sets status", v, 32'h1);
    rd(3'd2, v); check("R6 second reload", v, 32'd3);
    wr(3'd0, 32'h0);
    wr(3'd6, 32'h1);
  endtask

  task automatic t_override;
    logic [31:0] v;
    wr(3'd2, 32'd100);
    wr(3'd0, 32'h2);
    wr(3'd2, 32'd50);
    rd(3'd2, v); check("R8 write beats decrement", v, 32'd50);
    edges(1);
    rd(3'd2, v); check("R8 counting resumes", v, 32'd49);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_wdog_keys;
    logic [31:0] v;
    wr(3'd7, KA);
    wr(3'd7, 32'h1234_5678);
    wr(3'd7, KB);
    edges(5);
    rd(3'd7, v); check("R9 broken sequence not armed", v, 32'd0);
    wr(3'd7, KB);
    rd(3'd7, v); check("R9 second key alone not armed", v, 32'd0);
    check("R9 no reset request", 32'(wdog_reset_req), 32'h0);
  endtask

  task automatic t_wdog_run;
    logic [31:0] v;
    wr(3'd7, KA);
    wr(3'd7, KB);
    rd(3'd7, v); check("R10 armed loads start", v, 32'(WDS));
    edges(10);
    rd(3'd7, v); check("R10 counts per clock", v, 32'(WDS - 10));
    wr(3'd7, 32'h0);
    rd(3'd7, v); check("R10 other write does not stop", v, 32'(WDS - 11));
    wr(3'd7, KA);
    wr(3'd7, KB);
    rd(3'd7, v); check("R10 service reloads", v, 32'(WDS));
    edges(WDS);
    rd(3'd7, v); check("R11 count reaches zero", v, 32'd0);
    check("R11 no request yet", 32'(wdog_reset_req), 32'h0);
    edges(1);
    check("R11 request raised", 32'(wdog_reset_req), 32'h1);
    wr(3'd7, KA);
    wr(3'd7, KB);
    edges(3);
    check("R11 request sticky", 32'(wdog_reset_req), 32'h1);
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog timeout actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    edges(3);
    t_reset();
    t_oneshot();
    t_div4();
    t_partial_clear();
    t_autoreload();
    t_override();
    t_wdog_keys();
    t_wdog_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule